// File: doc/BRIEF.md
# Dual-Length Serial Configuration Shift Register

This block is the serial loading path of a 16-channel LED sink driver. A serial bit stream enters on `sin`, one bit for each single-cycle `shift_en` strobe, most significant bit first. The active length of the shift chain follows the mode input. In brightness mode it is 192 bits, which is 16 channels of 12-bit PWM levels. In correction mode it is 96 bits, which is 16 channels of 6-bit current-trim values. Whatever falls off the top of the active length appears on `sout`, so several devices can be chained into one long stream.

The `xlat` input moves the shifted data into the held registers. In brightness mode its rising edge loads the 12-bit levels and takes effect at once. In correction mode the trim register follows the shift chain for as long as `xlat` is high, and it freezes when `xlat` falls. After every brightness load the chain is overwritten with a 192-bit status word, which a controller reads back by shifting in the next frame. The status word carries the per-channel open-load flags, the over-temperature flag, and the trim data. The trim data comes either from the live trim register or from a non-volatile copy. That copy is modelled here as a stub register that holds all ones. The first brightness load after a trim write is deferred until one more shift strobe arrives.

Top module: `serial_cfg_shifter`

## Requirements
- R1: After reset, `sout`, every bit of `gs_levels` and every bit of `dc_levels` are 0.
- R2: With `mode_dc`=0, each `shift_en` strobe moves the chain up one bit and takes `sin` in at bit 0. `sout` is chain bit 191, so a bit appears on `sout` after 192 strobes.
- R3: With `mode_dc`=1, `sout` is chain bit 95, so a bit shifted in appears on `sout` after 96 strobes.
- R4: With `mode_dc`=1 and `xlat`=1, `dc_levels` shows chain bits 95..0 in the same cycle. Once `xlat` is low, `dc_levels` holds its value regardless of shifting.
- R5: With `mode_dc`=0, a rising edge of `xlat` copies chain bits 191..0 to `gs_levels` at that clock edge. Channel n occupies bits 12n+11..12n.
- R6: Each brightness load replaces the chain with a status word. Bits 15..0 are the `led_open` flags sampled at that edge, bit 16 is `over_temp`, and bits 23..17 and 191..120 are 0.
- R7: Status bits 119..24 hold `dc_levels` when `dc_src_sel`=1 and hold the stored copy when `dc_src_sel`=0. The stored copy resets to all ones.
- R8: Right after a status load, `sout` shows status bit 191, which is 0. Each later strobe presents the next lower status bit.
- R9: After any trim write, the next brightness `xlat` edge does not change `gs_levels`. The following `shift_en` strobe completes the load with the chain contents from before that strobe, and it discards that strobe's `sin` bit.
- R10: Holding `xlat` high in brightness mode loads `gs_levels` only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_en | input | 1 | One-cycle serial shift strobe |
| sin | input | 1 | Serial data in, MSB first |
| xlat | input | 1 | Latch control |
| mode_dc | input | 1 | 0 = brightness mode (192 bits), 1 = correction mode (96 bits) |
| dc_src_sel | input | 1 | Status trim source: 1 = live register, 0 = stored copy |
| led_open | input | 16 | Per-channel open-load flags |
| over_temp | input | 1 | Over-temperature flag |
| sout | output | 1 | Serial data out (top of active length) |
| gs_levels | output | 192 | 16 x 12-bit PWM levels |
| dc_levels | output | 96 | 16 x 6-bit current trims |

## Verification
A shift strobe registers at the clock edge where it is seen, so the new `sout` is sampled at the following falling edge. A brightness latch or status load likewise shows on `gs_levels` and `sout` at the falling edge after the first clock edge that sees `xlat` high. The trim register is transparent, so it is sampled 1 ns after `xlat` rises with no clock edge in between. The driver queues one expected `sout` value per strobe. The monitor pops that value exactly one half-period after the strobe's edge, so each serial bit is compared in the cycle it becomes valid, and the deferred-load case checks that `gs_levels` stays put until the extra strobe.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  typedef enum logic {
    MODE_GS = 1'b0,
    MODE_DC = 1'b1
  } scfg_mode_e;
endpackage

// File: rtl/scfg_ctrl.sv
// Latch sequencing: xlat edge detection, deferred brightness load after a trim write.
module scfg_ctrl
  import scfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_en,
  input  logic       xlat,
  input  scfg_mode_e mode,
  output logic       ev_shift,
  output logic       ev_gs_load,
  output logic       ev_status_load,
  output logic       ev_dc_open,
  output logic       armed
);
  logic xlat_q;
  logic pend_q;
  logic arm_q;
  logic gs_rise;
  logic arm_done;

  assign gs_rise        = xlat && !xlat_q && (mode == MODE_GS);
  assign arm_done       = arm_q && shift_en;
  assign ev_dc_open     = xlat && (mode == MODE_DC);
  assign ev_gs_load     = (gs_rise && !pend_q) || arm_done;
  assign ev_status_load = ev_gs_load;
  assign ev_shift       = shift_en && !ev_status_load;
  assign armed          = arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlat_q <= 1'b0;
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      xlat_q <= xlat;
      if (ev_dc_open)
        pend_q <= 1'b1;
      else if (arm_done)
        pend_q <= 1'b0;
      if (gs_rise && pend_q)
        arm_q <= 1'b1;
      else if (arm_done)
        arm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/scfg_shifter.sv
// Serial chain with mode-dependent output tap and status reload.
module scfg_shifter
  import scfg_pkg::*;
#(
  parameter int CH     = 16,
  parameter int GS_W   = 12,
  parameter int DC_W   = 6,
  parameter int DC_LSB = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_shift,
  input  logic                    ev_status_load,
  input  scfg_mode_e              mode,
  input  logic                    sin,
  input  logic [CH-1:0]           led_open,
  input  logic                    over_temp,
  input  logic [CH*DC_W-1:0]      dc_src,
  output logic [CH*GS_W-1:0]      sreg_q,
  output logic                    sout
);
  localparam int GS_LEN    = CH * GS_W;
  localparam int DC_LEN    = CH * DC_W;
  localparam int THERM_BIT = CH;
  localparam int DC_MSB    = DC_LSB + DC_LEN - 1;

  function automatic logic [GS_LEN-1:0] build_status(
    input logic [CH-1:0]     open_f,
    input logic              hot,
    input logic [DC_LEN-1:0] trim
  );
    logic [GS_LEN-1:0] w;
    w = '0;
    w[CH-1:0]         = open_f;
    w[THERM_BIT]      = hot;
    w[DC_MSB:DC_LSB]  = trim;
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sreg_q <= '0;
    else if (ev_status_load)
      sreg_q <= build_status(led_open, over_temp, dc_src);
    else if (ev_shift)
      sreg_q <= {sreg_q[GS_LEN-2:0], sin};
  end

  assign sout = (mode == MODE_DC) ? sreg_q[DC_LEN-1] : sreg_q[GS_LEN-1];
endmodule

// File: rtl/scfg_regs.sv
// Held brightness levels, transparent trim register, stored trim copy.
module scfg_regs #(
  parameter int CH   = 16,
  parameter int GS_W = 12,
  parameter int DC_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_gs_load,
  input  logic                 ev_dc_open,
  input  logic                 dc_src_sel,
  input  logic [CH*GS_W-1:0]   sreg_q,
  output logic [CH*GS_W-1:0]   gs_levels,
  output logic [CH*DC_W-1:0]   dc_levels,
  output logic [CH*DC_W-1:0]   dc_src
);
  localparam int DC_LEN = CH * DC_W;

  logic [DC_LEN-1:0] rom_q;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [GS_W-1:0] gs_q;
    logic [DC_W-1:0] dc_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        gs_q <= '0;
      else if (ev_gs_load)
        gs_q <= sreg_q[c*GS_W +: GS_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dc_q <= '0;
      else if (ev_dc_open)
        dc_q <= sreg_q[c*DC_W +: DC_W];
    end

    assign gs_levels[c*GS_W +: GS_W] = gs_q;
    assign dc_levels[c*DC_W +: DC_W] = ev_dc_open ? sreg_q[c*DC_W +: DC_W] : dc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rom_q <= '1;
  end

  assign dc_src = dc_src_sel ? dc_levels : rom_q;
endmodule

// File: rtl/serial_cfg_shifter.sv
module serial_cfg_shifter
  import scfg_pkg::*;
#(
  parameter int CH     = 16,
  parameter int GS_W   = 12,
  parameter int DC_W   = 6,
  parameter int DC_LSB = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 sin,
  input  logic                 xlat,
  input  logic                 mode_dc,
  input  logic                 dc_src_sel,
  input  logic [CH-1:0]        led_open,
  input  logic                 over_temp,
  output logic                 sout,
  output logic [CH*GS_W-1:0]   gs_levels,
  output logic [CH*DC_W-1:0]   dc_levels
);
  localparam int GS_LEN = CH * GS_W;
  localparam int DC_LEN = CH * DC_W;

  scfg_mode_e        mode;
  logic              ev_shift;
  logic              ev_gs_load;
  logic              ev_status_load;
  logic              ev_dc_open;
  logic              armed;
  logic [GS_LEN-1:0] sreg_q;
  logic [DC_LEN-1:0] dc_src;

  assign mode = scfg_mode_e'(mode_dc);

  scfg_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .shift_en       (shift_en),
    .xlat           (xlat),
    .mode           (mode),
    .ev_shift       (ev_shift),
    .ev_gs_load     (ev_gs_load),
    .ev_status_load (ev_status_load),
    .ev_dc_open     (ev_dc_open),
    .armed          (armed)
  );

  scfg_shifter #(.CH(CH), .GS_W(GS_W), .DC_W(DC_W), .DC_LSB(DC_LSB)) u_shift (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_shift       (ev_shift),
    .ev_status_load (ev_status_load),
    .mode           (mode),
    .sin            (sin),
    .led_open       (led_open),
    .over_temp      (over_temp),
    .dc_src         (dc_src),
    .sreg_q         (sreg_q),
    .sout           (sout)
  );

  scfg_regs #(.CH(CH), .GS_W(GS_W), .DC_W(DC_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_gs_load (ev_gs_load),
    .ev_dc_open (ev_dc_open),
    .dc_src_sel (dc_src_sel),
    .sreg_q     (sreg_q),
    .gs_levels  (gs_levels),
    .dc_levels  (dc_levels),
    .dc_src     (dc_src)
  );
endmodule

// File: rtl/serial_cfg_shifter_chk.sv
module serial_cfg_shifter_chk #(
  parameter int CH   = 16,
  parameter int GS_W = 12,
  parameter int DC_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               shift_en,
  input logic               sin,
  input logic               xlat,
  input logic [CH-1:0]      led_open,
  input logic               over_temp,
  input logic [CH*GS_W-1:0] gs_levels,
  input logic [CH*DC_W-1:0] dc_levels,
  input logic               ev_gs_load,
  input logic               ev_status_load,
  input logic               armed,
  input logic               sreg_lsb,
  input logic [CH:0]        sreg_flags,
  input logic               sreg_msb
);
  // R2: a plain shift takes sin into bit 0
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !ev_status_load) |=> (sreg_lsb == $past(sin)));

  // R4: trim outputs frozen while xlat stays low
  a_r4_dc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xlat && !$past(xlat)) |-> $stable(dc_levels));

  // R5: brightness levels change only on a load event
  a_r5_gs_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_gs_load |=> $stable(gs_levels));

  // R6: status flags captured from inputs
  a_r6_status_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_status_load |=> (sreg_flags == {$past(over_temp), $past(led_open)}));

  // R8: status word top bit is reserved zero
  a_r8_status_msb: assert property (@(posedge clk) disable iff (!rst_n)
    ev_status_load |=> (sreg_msb == 1'b0));

  // R9: an armed load waits for a strobe
  a_r9_armed_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !shift_en) |=> $stable(gs_levels));

  // R10: no two loads in consecutive cycles
  a_r10_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gs_load |=> !ev_gs_load);
endmodule

bind serial_cfg_shifter serial_cfg_shifter_chk #(.CH(CH), .GS_W(GS_W), .DC_W(DC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .shift_en       (shift_en),
  .sin            (sin),
  .xlat           (xlat),
  .led_open       (led_open),
  .over_temp      (over_temp),
  .gs_levels      (gs_levels),
  .dc_levels      (dc_levels),
  .ev_gs_load     (ev_gs_load),
  .ev_status_load (ev_status_load),
  .armed          (armed),
  .sreg_lsb       (sreg_q[0]),
  .sreg_flags     (sreg_q[CH:0]),
  .sreg_msb       (sreg_q[CH*GS_W-1])
);

// File: tb/serial_cfg_shifter_tb.sv
module serial_cfg_shifter_tb;
  localparam int CH = 16, GS_W = 12, DC_W = 6;
  localparam int GL = CH * GS_W, DL = CH * DC_W;

  logic clk = 1'b0, rst_n = 1'b0, shift_en = 1'b0, sin = 1'b0, xlat = 1'b0;
  logic mode_dc = 1'b0, dc_src_sel = 1'b1, over_temp = 1'b0;
  logic [CH-1:0] led_open = '0;
  logic sout;
  logic [GL-1:0] gs_levels;
  logic [DL-1:0] dc_levels;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { bit chk; bit exp; string req; } sb_item_t;
  sb_item_t sbq[$];
  logic sh_seen = 1'b0;

  always #2 clk = ~clk;

  serial_cfg_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sin(sin), .xlat(xlat),
    .mode_dc(mode_dc), .dc_src_sel(dc_src_sel), .led_open(led_open),
    .over_temp(over_temp), .sout(sout), .gs_levels(gs_levels), .dc_levels(dc_levels)
  );

  task automatic check(input string req, input logic [GL-1:0] got, input logic [GL-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [GL-1:0] gs_pat(input int m, input int a);
    logic [GL-1:0] v;
    for (int c = 0; c < CH; c++) v[c*GS_W +: GS_W] = GS_W'(c * m + a);
    return v;
  endfunction

  function automatic logic [DL-1:0] dc_pat(input int m, input int a);
    logic [DL-1:0] v;
    for (int c = 0; c < CH; c++) v[c*DC_W +: DC_W] = DC_W'(c * m + a);
    return v;
  endfunction

  function automatic logic [GL-1:0] status(input logic [CH-1:0] f, input logic t, input logic [DL-1:0] d);
    logic [GL-1:0] w;
    w = '0;
    w[CH-1:0] = f;
    w[16] = t;
    w[24 +: DL] = d;
    return w;
  endfunction

  // monitor: pops one expected sout per strobe, half a period after its edge
  always @(posedge clk) sh_seen <= shift_en & rst_n;
  always @(negedge clk) begin
    if (sh_seen && sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      if (it.chk) check(it.req, GL'(sout), GL'(it.exp));
    end
  end

  task automatic shift_bit(input bit b, input bit chk, input bit exp, input string req);
    sb_item_t it;
    @(negedge clk);
    shift_en = 1'b1;
    sin = b;
    it.chk = chk; it.exp = exp; it.req = req;
    sbq.push_back(it);
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog got=timeout exp=finish");
    if (!done) begin
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DL-1:0] dca, dcb;
    logic [GL-1:0] gs1, gs2, gs3, st1, st2;
    dca = dc_pat(5, 3);
    dcb = dc_pat(7, 41);
    gs1 = gs_pat(273, 17);
    gs2 = gs_pat(611, 1234);
    gs3 = gs_pat(1999, 77);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sout", GL'(sout), '0);
    check("R1 gs", gs_levels, '0);
    check("R1 dc", GL'(dc_levels), '0);

    // correction mode, 96-bit length
    mode_dc = 1'b1;
    for (int k = 1; k <= DL; k++)
      shift_bit(dca[DL-k], 1, (k < DL) ? 1'b0 : dca[DL-1], "R3");
    @(negedge clk);
    xlat = 1'b1;
    #1 check("R4 transparent", GL'(dc_levels), GL'(dca));
    @(negedge clk);
    xlat = 1'b0;
    for (int k = 1; k <= DL; k++)
      shift_bit(dcb[DL-k], 1, (k < DL) ? dca[DL-1-k] : dcb[DL-1], "R3");
    @(negedge clk);
    check("R4 hold", GL'(dc_levels), GL'(dca));
    check("R5 no gs in dc mode", gs_levels, '0);

    // brightness mode, first load is deferred
    mode_dc = 1'b0;
    for (int k = 1; k <= GL; k++) shift_bit(gs1[GL-k], 0, 0, "");
    led_open = 16'hA5C3;
    over_temp = 1'b1;
    dc_src_sel = 1'b1;
    @(negedge clk);
    xlat = 1'b1;
    @(negedge clk);
    check("R9 deferred", gs_levels, '0);
    xlat = 1'b0;
    @(negedge clk);
    check("R9 still deferred", gs_levels, '0);
    shift_bit(1'b1, 1, 1'b0, "R8");
    check("R9 completed", gs_levels, gs1);
    st1 = status(16'hA5C3, 1'b1, dca);
    for (int k = 1; k <= GL; k++)
      shift_bit(gs2[GL-k], 1, (k < GL) ? st1[GL-1-k] : gs2[GL-1],
                ((GL-1-k) >= 24 && (GL-1-k) <= 119) ? "R7" : "R6");

    // immediate load, stored trim copy selected
    led_open = 16'h0001;
    over_temp = 1'b0;
    dc_src_sel = 1'b0;
    @(negedge clk);
    xlat = 1'b1;
    @(negedge clk);
    check("R5 immediate", gs_levels, gs2);
    check("R8 status msb", GL'(sout), '0);
    @(negedge clk);
    @(negedge clk);
    check("R10 once", gs_levels, gs2);
    xlat = 1'b0;
    st2 = status(16'h0001, 1'b0, '1);
    for (int k = 1; k <= GL; k++)
      shift_bit(gs3[GL-k], 1, (k < GL) ? st2[GL-1-k] : gs3[GL-1],
                ((GL-1-k) >= 24 && (GL-1-k) <= 119) ? "R7" : "R6");
    for (int k = 1; k <= GL; k++)
      shift_bit(1'b0, 1, (k < GL) ? gs3[GL-1-k] : 1'b0, "R2");
    @(negedge clk);
    @(negedge clk);
    check("R4 unchanged by brightness", GL'(dc_levels), GL'(dca));

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule